// File: doc/BRIEF.md
# Bank-Switched Memory Address Decoder

This block turns a 16-bit processor memory address into chip-select lines for two switchable RAM banks, one common RAM region and a boot ROM. The address space is split in two: a switched region starting at address 0000h, and a common region that runs from a programmable split point up to FFFFh. The split point moves in 1K steps between C000h and FC00h. Software picks the split and the active bank with one I/O write to a command port. A write to any other port leaves the setting unchanged.

A separate ROM-enable control lays a 4K boot ROM window over 0000h–0FFFh. Reads in that window go to the ROM ahead of any bank. Writes in that window reach no device. The ROM can be 4K or 2K. A 2K part appears twice in the window, because its top address line is held low. Reset leaves the ROM visible and all switched memory off, so the processor boots from ROM.

Top module: `mem_bank_decoder`

## Requirements
- R1: After reset the split code is 0 (split at C000h), the bank code is 0 (no switched select) and the ROM overlay is on.
- R2: A clocked cycle with `io_wr` high and `io_port` equal to 1Dh loads the split code from `io_wdata[7:4]` and the bank code from `io_wdata[1:0]`. Bits 3:2 are ignored, and writes to any other port change nothing.
- R3: A memory cycle at an address at or above C000h + split code × 0400h asserts `cs_common` only, whatever the bank code.
- R4: With bank code 0, a memory cycle below the split asserts no select. The ROM window is the one exception.
- R5: Below the split, bank code 1 asserts `cs_bank0` and bank code 2 asserts `cs_bank1`.
- R6: Bank code 3 is treated as bank code 1 and asserts `cs_bank0`.
- R7: With the ROM overlay on, a read at 0000h–0FFFh asserts `cs_rom` only, for any bank code.
- R8: With the ROM overlay on, a write at 0000h–0FFFh asserts no select.
- R9: A clocked cycle with `rom_en_we` high loads the ROM overlay state from `rom_en_val`. With the overlay off, addresses 0000h–0FFFh decode as switched memory.
- R10: `rom_addr` equals `addr[11:0]` when `rom_2k` is 0. When `rom_2k` is 1, bit 11 is forced to 0 and bits 10:0 follow the address.
- R11: At most one select is active at any time, and none is active while `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe, sampled on the clock edge |
| io_port | input | 8 | I/O port number of the write |
| io_wdata | input | 8 | I/O write data |
| rom_en_we | input | 1 | Load strobe for the ROM overlay state |
| rom_en_val | input | 1 | New ROM overlay state (1 = on) |
| rom_2k | input | 1 | ROM size: 1 = 2K part, 0 = 4K part |
| mem_req | input | 1 | A memory cycle is in progress |
| mem_wr | input | 1 | The memory cycle is a write |
| addr | input | 16 | Processor memory address |
| cs_bank0 | output | 1 | Select for switched bank 0 |
| cs_bank1 | output | 1 | Select for switched bank 1 |
| cs_common | output | 1 | Select for common RAM |
| cs_rom | output | 1 | Select for the boot ROM |
| rom_addr | output | 12 | Address lines to the ROM |

## Verification
The bench sweeps all sixteen split codes and probes the last switched address and the first common address for each. This shows whether the boundary compare is off by one step or by one byte. Each bank code, including the illegal code 3, is tried with addresses on both sides of the split. This separates the bank decode from the common decode. The ROM window is probed with reads and with writes, with the overlay on and off. It is also probed just past its top at 1000h, which separates overlay priority from the bank decode. Writes to a neighbouring port, and writes with bits 3:2 set, show that only the intended fields load.

// File: rtl/membank_pkg.sv
package membank_pkg;

    localparam int SPLIT_W = 4;
    localparam int BANK_W  = 2;

    typedef enum logic [BANK_W-1:0] {
        BSEL_NONE  = 2'd0,
        BSEL_LOW   = 2'd1,
        BSEL_HIGH  = 2'd2,
        BSEL_ALIAS = 2'd3
    } bank_code_e;

    typedef struct packed {
        logic [SPLIT_W-1:0] split;
        bank_code_e         bank;
        logic               rom_on;
    } map_cfg_t;

    typedef struct packed {
        logic rom;
        logic common;
        logic bank1;
        logic bank0;
    } chip_sel_t;

    localparam chip_sel_t SEL_IDLE = '{rom: 1'b0, common: 1'b0, bank1: 1'b0, bank0: 1'b0};

    // Codes 1 and 3 both land on the lower bank.
    function automatic logic picks_low(input bank_code_e code);
        return (code == BSEL_LOW) || (code == BSEL_ALIAS);
    endfunction

    function automatic logic picks_high(input bank_code_e code);
        return code == BSEL_HIGH;
    endfunction

endpackage

// File: rtl/membank_cfg_reg.sv
module membank_cfg_reg
    import membank_pkg::*;
#(
    parameter int          PORT_W   = 8,
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  CMD_PORT = 8'h1D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [PORT_W-1:0] io_port,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              rom_en_we,
    input  logic              rom_en_val,
    output map_cfg_t          cfg
);
    localparam int SPLIT_LSB = DATA_W - SPLIT_W;
    localparam logic [PORT_W-1:0] PORT_MATCH = PORT_W'(CMD_PORT);

    logic hit;
    assign hit = io_wr && (io_port == PORT_MATCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.split  <= '0;
            cfg.bank   <= BSEL_NONE;
            cfg.rom_on <= 1'b1;
        end else begin
            if (hit) begin
                cfg.split <= io_wdata[DATA_W-1:SPLIT_LSB];
                cfg.bank  <= bank_code_e'(io_wdata[BANK_W-1:0]);
            end
            if (rom_en_we) begin
                cfg.rom_on <= rom_en_val;
            end
        end
    end
endmodule

// File: rtl/membank_region.sv
module membank_region
    import membank_pkg::*;
#(
    parameter int                ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] SPLIT_BASE   = 16'hC000,
    parameter int                STEP_LOG2    = 10,
    parameter int                ROM_WIN_LOG2 = 12
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [SPLIT_W-1:0] split,
    output logic               above_split,
    output logic               in_rom_win
);
    logic [ADDR_W-1:0] split_addr;

    assign split_addr  = SPLIT_BASE + (ADDR_W'(split) << STEP_LOG2);
    assign above_split = addr >= split_addr;
    assign in_rom_win  = (addr[ADDR_W-1:ROM_WIN_LOG2] == '0);
endmodule

// File: rtl/membank_select.sv
module membank_select
    import membank_pkg::*;
(
    input  logic      mem_req,
    input  logic      mem_wr,
    input  logic      above_split,
    input  logic      in_rom_win,
    input  map_cfg_t  cfg,
    output chip_sel_t sel
);
    always_comb begin
        sel = SEL_IDLE;
        if (mem_req) begin
            if (cfg.rom_on && in_rom_win) begin
                // Overlay owns the window: reads hit ROM, writes hit nothing.
                sel.rom = !mem_wr;
            end else if (above_split) begin
                sel.common = 1'b1;
            end else begin
                sel.bank0 = picks_low(cfg.bank);
                sel.bank1 = picks_high(cfg.bank);
            end
        end
    end
endmodule

// File: rtl/membank_rom_addr.sv
module membank_rom_addr #(
    parameter int ROM_WIN_LOG2 = 12
) (
    input  logic [ROM_WIN_LOG2-1:0] addr_lo,
    input  logic                    rom_small,
    output logic [ROM_WIN_LOG2-1:0] rom_addr
);
    localparam int TOP = ROM_WIN_LOG2 - 1;

    for (genvar i = 0; i < ROM_WIN_LOG2; i++) begin : g_bit
        if (i == TOP) begin : g_fold
            assign rom_addr[i] = addr_lo[i] & ~rom_small;
        end else begin : g_pass
            assign rom_addr[i] = addr_lo[i];
        end
    end
endmodule

// File: rtl/mem_bank_decoder.sv
module mem_bank_decoder
    import membank_pkg::*;
#(
    parameter int                ADDR_W       = 16,
    parameter int                PORT_W       = 8,
    parameter int                DATA_W       = 8,
    parameter logic [7:0]        CMD_PORT     = 8'h1D,
    parameter logic [ADDR_W-1:0] SPLIT_BASE   = 16'hC000,
    parameter int                STEP_LOG2    = 10,
    parameter int                ROM_WIN_LOG2 = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    io_wr,
    input  logic [PORT_W-1:0]       io_port,
    input  logic [DATA_W-1:0]       io_wdata,
    input  logic                    rom_en_we,
    input  logic                    rom_en_val,
    input  logic                    rom_2k,
    input  logic                    mem_req,
    input  logic                    mem_wr,
    input  logic [ADDR_W-1:0]       addr,
    output logic                    cs_bank0,
    output logic                    cs_bank1,
    output logic                    cs_common,
    output logic                    cs_rom,
    output logic [ROM_WIN_LOG2-1:0] rom_addr
);
    map_cfg_t  cfg;
    chip_sel_t sel;
    logic      above_split;
    logic      in_rom_win;

    membank_cfg_reg #(
        .PORT_W   (PORT_W),
        .DATA_W   (DATA_W),
        .CMD_PORT (CMD_PORT)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .io_wr      (io_wr),
        .io_port    (io_port),
        .io_wdata   (io_wdata),
        .rom_en_we  (rom_en_we),
        .rom_en_val (rom_en_val),
        .cfg        (cfg)
    );

    membank_region #(
        .ADDR_W       (ADDR_W),
        .SPLIT_BASE   (SPLIT_BASE),
        .STEP_LOG2    (STEP_LOG2),
        .ROM_WIN_LOG2 (ROM_WIN_LOG2)
    ) u_region (
        .addr        (addr),
        .split       (cfg.split),
        .above_split (above_split),
        .in_rom_win  (in_rom_win)
    );

    membank_select u_sel (
        .mem_req     (mem_req),
        .mem_wr      (mem_wr),
        .above_split (above_split),
        .in_rom_win  (in_rom_win),
        .cfg         (cfg),
        .sel         (sel)
    );

    membank_rom_addr #(
        .ROM_WIN_LOG2 (ROM_WIN_LOG2)
    ) u_rom_addr (
        .addr_lo   (addr[ROM_WIN_LOG2-1:0]),
        .rom_small (rom_2k),
        .rom_addr  (rom_addr)
    );

    assign cs_bank0  = sel.bank0;
    assign cs_bank1  = sel.bank1;
    assign cs_common = sel.common;
    assign cs_rom    = sel.rom;
endmodule

// File: rtl/mem_bank_decoder_chk.sv
module mem_bank_decoder_chk #(
    parameter int ADDR_W       = 16,
    parameter int ROM_WIN_LOG2 = 12
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    rom_2k,
    input logic                    mem_req,
    input logic                    mem_wr,
    input logic [ADDR_W-1:0]       addr,
    input logic                    cs_bank0,
    input logic                    cs_bank1,
    input logic                    cs_common,
    input logic                    cs_rom,
    input logic [ROM_WIN_LOG2-1:0] rom_addr
);
    logic win;
    logic top_k;
    assign win   = (addr[ADDR_W-1:ROM_WIN_LOG2] == '0);
    assign top_k = (addr[ADDR_W-1:10] == '1);

    a_r11_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cs_bank0, cs_bank1, cs_common, cs_rom}));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !mem_req |-> !(cs_bank0 || cs_bank1 || cs_common || cs_rom));

    a_r3_top_common: assert property (@(posedge clk) disable iff (rst)
        (mem_req && top_k) |-> cs_common);

    a_r8_rom_read_only: assert property (@(posedge clk) disable iff (rst)
        cs_rom |-> (!mem_wr && win));

    a_r1_boot_rom: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && mem_req && !mem_wr && win) |-> cs_rom);

    a_r10_small_fold: assert property (@(posedge clk) disable iff (rst)
        rom_2k |-> !rom_addr[ROM_WIN_LOG2-1]);

    a_r10_full_pass: assert property (@(posedge clk) disable iff (rst)
        !rom_2k |-> (rom_addr == addr[ROM_WIN_LOG2-1:0]));
endmodule

bind mem_bank_decoder mem_bank_decoder_chk #(
    .ADDR_W       (ADDR_W),
    .ROM_WIN_LOG2 (ROM_WIN_LOG2)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rom_2k    (rom_2k),
    .mem_req   (mem_req),
    .mem_wr    (mem_wr),
    .addr      (addr),
    .cs_bank0  (cs_bank0),
    .cs_bank1  (cs_bank1),
    .cs_common (cs_common),
    .cs_rom    (cs_rom),
    .rom_addr  (rom_addr)
);

// File: tb/sim_mem_bank_decoder.sv
`timescale 1ns/1ps
module sim_mem_bank_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr = 1'b0;
    logic [7:0]  io_port = 8'h00;
    logic [7:0]  io_wdata = 8'h00;
    logic        rom_en_we = 1'b0;
    logic        rom_en_val = 1'b0;
    logic        rom_2k = 1'b0;
    logic        mem_req = 1'b0;
    logic        mem_wr = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        cs_bank0, cs_bank1, cs_common, cs_rom;
    logic [11:0] rom_addr;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mem_bank_decoder u0 (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_port(io_port), .io_wdata(io_wdata),
        .rom_en_we(rom_en_we), .rom_en_val(rom_en_val), .rom_2k(rom_2k),
        .mem_req(mem_req), .mem_wr(mem_wr), .addr(addr),
        .cs_bank0(cs_bank0), .cs_bank1(cs_bank1), .cs_common(cs_common),
        .cs_rom(cs_rom), .rom_addr(rom_addr)
    );

    // selects packed as {rom, common, bank1, bank0}
    localparam logic [3:0] S_NONE = 4'b0000;
    localparam logic [3:0] S_B0   = 4'b0001;
    localparam logic [3:0] S_B1   = 4'b0010;
    localparam logic [3:0] S_COM  = 4'b0100;
    localparam logic [3:0] S_ROM  = 4'b1000;

    task automatic cfg_write(input logic [7:0] port, input logic [7:0] data);
        @(negedge clk);
        io_wr = 1'b1; io_port = port; io_wdata = data;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rom_ctl(input logic on);
        @(negedge clk);
        rom_en_we = 1'b1; rom_en_val = on;
        @(negedge clk);
        rom_en_we = 1'b0;
    endtask

    task automatic probe(input logic req, input logic wr, input logic [15:0] a,
                         input logic [3:0] exp, input string tag);
        logic [3:0] got;
        @(negedge clk);
        mem_req = req; mem_wr = wr; addr = a;
        #1;
        got = {cs_rom, cs_common, cs_bank1, cs_bank0};
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h wr=%0b actual=%b expected=%b", tag, a, wr, got, exp);
        end
    endtask

    task automatic t_reset;
        probe(1, 0, 16'h0000, S_ROM,  "R1 rom on after reset");
        probe(1, 0, 16'h2000, S_NONE, "R1 no bank after reset");
        probe(1, 0, 16'hBFFF, S_NONE, "R1 split C000 low side");
        probe(1, 0, 16'hC000, S_COM,  "R1 split C000 high side");
    endtask

    task automatic t_load_and_ignore;
        cfg_write(8'h1D, 8'h51);
        probe(1, 0, 16'hD3FF, S_B0,  "R5 code1 bank0");
        probe(1, 0, 16'hD400, S_COM, "R3 split D400");
        cfg_write(8'h1C, 8'h02);
        probe(1, 0, 16'hD3FF, S_B0,  "R2 other port ignored");
        probe(1, 0, 16'hD400, S_COM, "R2 other port split kept");
        cfg_write(8'h1D, 8'h0E);
        probe(1, 0, 16'hBFFF, S_B1,  "R5 code2 bank1 (R2 bits3:2 ignored)");
        probe(1, 1, 16'hC000, S_COM, "R3 common write");
    endtask

    task automatic t_alias_and_none;
        cfg_write(8'h1D, 8'hF3);
        probe(1, 0, 16'hFBFF, S_B0,  "R6 code3 aliases bank0");
        probe(1, 0, 16'hFC00, S_COM, "R3 split FC00");
        cfg_write(8'h1D, 8'hF0);
        probe(1, 0, 16'h4000, S_NONE, "R4 code0 nothing");
        probe(1, 1, 16'hFBFF, S_NONE, "R4 code0 write nothing");
        probe(1, 0, 16'hFFFF, S_COM,  "R3 top common");
    endtask

    task automatic t_sweep;
        for (int c = 0; c < 16; c++) begin
            logic [15:0] edge_a;
            edge_a = 16'hC000 + 16'(c) * 16'h0400;
            cfg_write(8'h1D, {4'(c), 4'b0010});
            probe(1, 0, edge_a - 16'd1, S_B1,  "R3 sweep below split");
            probe(1, 0, edge_a,         S_COM, "R3 sweep at split");
        end
    endtask

    task automatic t_rom;
        cfg_write(8'h1D, 8'h51);
        probe(1, 0, 16'h0800, S_ROM,  "R7 rom read priority");
        probe(1, 0, 16'h0FFF, S_ROM,  "R7 rom window top");
        probe(1, 1, 16'h0800, S_NONE, "R8 rom window write");
        probe(1, 0, 16'h1000, S_B0,   "R7 past window");
        rom_ctl(1'b0);
        probe(1, 0, 16'h0800, S_B0,   "R9 overlay off read");
        probe(1, 1, 16'h0000, S_B0,   "R9 overlay off write");
        rom_ctl(1'b1);
        probe(1, 0, 16'h0000, S_ROM,  "R9 overlay back on");
        probe(0, 0, 16'h0800, S_NONE, "R11 idle no select");
        probe(0, 1, 16'hFFFF, S_NONE, "R11 idle high addr");
    endtask

    task automatic t_rom_addr;
        @(negedge clk);
        rom_2k = 1'b0; addr = 16'h0ABC; #1;
        n_run++;
        if (rom_addr !== 12'hABC) begin
            n_fail++;
            $display("FAIL R10 4K actual=%h expected=%h", rom_addr, 12'hABC);
        end
        @(negedge clk);
        rom_2k = 1'b1; #1;
        n_run++;
        if (rom_addr !== 12'h2BC) begin
            n_fail++;
            $display("FAIL R10 2K fold actual=%h expected=%h", rom_addr, 12'h2BC);
        end
        rom_2k = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_load_and_ignore;
        t_alias_and_none;
        t_sweep;
        t_rom;
        t_rom_addr;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule